// File: doc/BRIEF.md
# SCSI Bus-Master DMA Control Block

This block is the register and sequencing core of a bus-master DMA adapter that sits between a host bus and an 8-bit SCSI bus controller. Software sets the transfer direction, the start address and the byte count through a small 16-bit register port. The block then moves bytes over a request/acknowledge handshake with the SCSI controller and issues one memory strobe per byte. It keeps a residual byte count that software reads back after a transfer to learn how far the transfer got.

The enable bit has a second job: the SCSI controller's interrupt reaches the host only while the engine is enabled. The interrupt is also held back while any count remains or while a byte sits in the one-byte staging FIFO. To let interrupts through with no data movement, software loads a zero count and sets enable.

In the memory-to-SCSI direction the engine fetches each byte one step ahead of the handshake. A transfer that stops early therefore reports a residual one below the true remainder. Sticky error flags for a DMA conflict and a host bus error stop the engine until software pulses the active-low FIFO reset.

Top module: `scsi_dma_ctl`

## Requirements
- R1: After reset the control word (select 0) reads 0x0004, selects 1 to 5 read 0, and dev_ack, both memory strobes and host_irq are low.
- R2: The control word has run at bit 0, send at bit 1 (1 = memory to SCSI) and FIFO release at bit 2 (active low). Bits 8, 9 and 10 are read-only: conflict error, bus error, and FIFO holding a byte. A write to bits 8 to 10 has no effect.
- R3: The address is written as its upper bits at select 1 and its lower 16 bits at select 2. Bit 0 of a low-half write is stored as 0. The address advances by one on each memory strobe and is driven on dma_addr.
- R4: A write to select 3 or 4 loads that half of the transfer count and the same half of the residual. A write to select 5 loads the residual with the written value and clears its upper bits. Selects 3 and 4 read back the programmed count; select 5 reads the low 16 bits of the residual.
- R5: With send clear, run set and a non-zero residual, a dev_req seen at a clock edge gives a one-cycle dev_ack together with mem_wr_stb in the next cycle. The residual drops by one per acknowledged byte, and no acknowledge follows once it reaches zero.
- R6: With send set, the engine pulses mem_rd_stb to fetch a byte into the FIFO before that byte is acknowledged, and the residual drops at each fetch. A full transfer ends at residual 0. After a partial transfer the residual is one less than the bytes not yet sent.
- R7: With run set and a zero residual and an empty FIFO, no strobe and no dev_ack occur.
- R8: host_irq follows scsi_irq only while run is set; with run clear it is low.
- R9: host_irq is also low while the residual is non-zero or the FIFO holds a byte.
- R10: The error inputs set sticky flags. While the FIFO release bit is 0, both flags and the FIFO byte are cleared and pack_flush is high.
- R11: While either error flag is set, no byte is fetched or acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 3 | Register select for read and write |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for host_sel |
| scsi_irq | input | 1 | Interrupt from the SCSI controller |
| host_irq | output | 1 | Gated interrupt to the host |
| dev_req | input | 1 | Byte request from the SCSI controller |
| dev_ack | output | 1 | Byte acknowledge to the SCSI controller |
| mem_rd_stb | output | 1 | One-byte memory fetch strobe |
| mem_wr_stb | output | 1 | One-byte memory write strobe |
| dma_addr | output | ADDR_W | Current memory byte address |
| err_conflict | input | 1 | DMA conflict event pulse |
| err_bus | input | 1 | Host bus error event pulse |
| pack_flush | output | 1 | Clear for the byte packing datapath |

## Verification
The assertions assume that dev_req and the error inputs are synchronous to clk, and that host writes never change the send bit while a byte is being fetched or acknowledged. The stimulus changes every input only on the falling edge. It changes direction only after run is cleared or the residual has drained. Requests are raised either as steady levels or as single-cycle pulses that start only after the FIFO has settled, so the counts of acknowledges and strobes are exact.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL    = 3'd0,
      SEL_ADDR_HI = 3'd1,
      SEL_ADDR_LO = 3'd2,
      SEL_CNT_HI  = 3'd3,
      SEL_CNT_LO  = 3'd4,
      SEL_RESID   = 3'd5
   } reg_sel_e;

   localparam int BIT_RUN   = 0;
   localparam int BIT_SEND  = 1;
   localparam int BIT_REL   = 2;
   localparam int BIT_CONF  = 8;
   localparam int BIT_BERR  = 9;
   localparam int BIT_HELD  = 10;
   localparam int HALF_W    = 16;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
   import scsi_dma_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          wr_sel,
   input  logic [15:0]       wr_data,
   input  logic              ev_conf,
   input  logic              ev_berr,
   input  logic              addr_step,
   output logic              run,
   output logic              send,
   output logic              fifo_rel,
   output logic              sticky_conf,
   output logic              sticky_berr,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  count
);
   localparam int AHW = ADDR_W - HALF_W;
   localparam int CHW = CNT_W - HALF_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         send     <= 1'b0;
         fifo_rel <= 1'b1;
      end else if (wr_en && wr_sel == SEL_CTRL) begin
         run      <= wr_data[BIT_RUN];
         send     <= wr_data[BIT_SEND];
         fifo_rel <= wr_data[BIT_REL];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (wr_en && wr_sel == SEL_ADDR_HI) begin
         addr[ADDR_W-1:HALF_W] <= wr_data[AHW-1:0];
      end else if (wr_en && wr_sel == SEL_ADDR_LO) begin
         addr[HALF_W-1:0] <= {wr_data[15:1], 1'b0};
      end else if (addr_step) begin
         addr <= addr + ADDR_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (wr_en && wr_sel == SEL_CNT_HI) begin
         count[CNT_W-1:HALF_W] <= wr_data[CHW-1:0];
      end else if (wr_en && wr_sel == SEL_CNT_LO) begin
         count[HALF_W-1:0] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_conf <= 1'b0;
         sticky_berr <= 1'b0;
      end else if (!fifo_rel) begin
         sticky_conf <= 1'b0;
         sticky_berr <= 1'b0;
      end else begin
         sticky_conf <= sticky_conf | ev_conf;
         sticky_berr <= sticky_berr | ev_berr;
      end
   end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
   import scsi_dma_pkg::*;
#(
   parameter int CNT_W         = 24,
   parameter bit SEND_PREFETCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             send,
   input  logic             flush,
   input  logic             ld_hi,
   input  logic             ld_lo,
   input  logic             ld_direct,
   input  logic [15:0]      ld_data,
   input  logic             dev_req,
   output logic             dev_ack,
   output logic             mem_rd_stb,
   output logic             mem_wr_stb,
   output logic             held,
   output logic [CNT_W-1:0] resid
);
   localparam int CHW = CNT_W - HALF_W;

   logic dec;
   logic nz;
   assign nz = |resid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         resid <= '0;
      else if (ld_hi)     resid[CNT_W-1:HALF_W] <= ld_data[CHW-1:0];
      else if (ld_lo)     resid[HALF_W-1:0] <= ld_data;
      else if (ld_direct) resid <= CNT_W'(ld_data);
      else if (dec)       resid <= resid - CNT_W'(1);
   end

   generate
      if (SEND_PREFETCH) begin : g_prefetch
         logic fetch_q, staged, ack_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fetch_q <= 1'b0;
               staged  <= 1'b0;
               ack_q   <= 1'b0;
            end else begin
               fetch_q <= go && send && nz && !staged && !fetch_q;
               ack_q   <= go && dev_req && !ack_q && (send ? staged : nz);
               if (flush)              staged <= 1'b0;
               else if (fetch_q)       staged <= 1'b1;
               else if (ack_q && send) staged <= 1'b0;
            end
         end
         assign dev_ack    = ack_q;
         assign mem_rd_stb = fetch_q;
         assign mem_wr_stb = ack_q && !send;
         assign held       = staged;
         assign dec        = fetch_q || (ack_q && !send);
      end else begin : g_direct
         logic ack_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= go && dev_req && !ack_q && nz;
         end
         assign dev_ack    = ack_q;
         assign mem_rd_stb = ack_q && send;
         assign mem_wr_stb = ack_q && !send;
         assign held       = 1'b0;
         assign dec        = ack_q;
      end
   endgenerate
endmodule

// File: rtl/sdma_irq_gate.sv
module sdma_irq_gate (
   input  logic run,
   input  logic busy,
   input  logic src_irq,
   output logic out_irq
);
   assign out_irq = run && !busy && src_irq;
endmodule

// File: rtl/scsi_dma_ctl.sv
module scsi_dma_ctl
   import scsi_dma_pkg::*;
#(
   parameter int ADDR_W        = 24,
   parameter int CNT_W         = 24,
   parameter bit SEND_PREFETCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [2:0]        host_sel,
   input  logic [15:0]       host_wdata,
   output logic [15:0]       host_rdata,
   input  logic              scsi_irq,
   output logic              host_irq,
   input  logic              dev_req,
   output logic              dev_ack,
   output logic              mem_rd_stb,
   output logic              mem_wr_stb,
   output logic [ADDR_W-1:0] dma_addr,
   input  logic              err_conflict,
   input  logic              err_bus,
   output logic              pack_flush
);
   localparam int AHW = ADDR_W - HALF_W;
   localparam int CHW = CNT_W - HALF_W;

   generate
      if (ADDR_W < 17 || ADDR_W > 32) begin : g_bad_addr
         $error("scsi_dma_ctl: ADDR_W must lie in 17..32");
      end
      if (CNT_W < 17 || CNT_W > 32) begin : g_bad_cnt
         $error("scsi_dma_ctl: CNT_W must lie in 17..32");
      end
   endgenerate

   reg_sel_e          sel;
   logic              run, send, fifo_rel, sticky_conf, sticky_berr, held;
   logic [CNT_W-1:0]  count, resid;
   logic [ADDR_W-1:0] addr;
   logic              go;

   assign sel = reg_sel_e'(host_sel);
   assign go  = run && fifo_rel && !sticky_conf && !sticky_berr;

   sdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(host_wr), .wr_sel(sel), .wr_data(host_wdata),
      .ev_conf(err_conflict), .ev_berr(err_bus),
      .addr_step(mem_rd_stb || mem_wr_stb),
      .run(run), .send(send), .fifo_rel(fifo_rel),
      .sticky_conf(sticky_conf), .sticky_berr(sticky_berr),
      .addr(addr), .count(count)
   );

   sdma_engine #(.CNT_W(CNT_W), .SEND_PREFETCH(SEND_PREFETCH)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .go(go), .send(send), .flush(!fifo_rel),
      .ld_hi(host_wr && sel == SEL_CNT_HI),
      .ld_lo(host_wr && sel == SEL_CNT_LO),
      .ld_direct(host_wr && sel == SEL_RESID),
      .ld_data(host_wdata),
      .dev_req(dev_req), .dev_ack(dev_ack),
      .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb),
      .held(held), .resid(resid)
   );

   sdma_irq_gate u_irq (
      .run(run), .busy(held || (|resid)),
      .src_irq(scsi_irq), .out_irq(host_irq)
   );

   assign dma_addr   = addr;
   assign pack_flush = !fifo_rel;

   always_comb begin
      host_rdata = '0;
      case (sel)
         SEL_CTRL: begin
            host_rdata[BIT_RUN]  = run;
            host_rdata[BIT_SEND] = send;
            host_rdata[BIT_REL]  = fifo_rel;
            host_rdata[BIT_CONF] = sticky_conf;
            host_rdata[BIT_BERR] = sticky_berr;
            host_rdata[BIT_HELD] = held;
         end
         SEL_ADDR_HI: host_rdata[AHW-1:0] = addr[ADDR_W-1:HALF_W];
         SEL_ADDR_LO: host_rdata          = addr[HALF_W-1:0];
         SEL_CNT_HI:  host_rdata[CHW-1:0] = count[CNT_W-1:HALF_W];
         SEL_CNT_LO:  host_rdata          = count[HALF_W-1:0];
         SEL_RESID:   host_rdata          = resid[HALF_W-1:0];
         default:     host_rdata          = '0;
      endcase
   end
endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             fifo_rel,
   input logic             held,
   input logic             sticky_conf,
   input logic             sticky_berr,
   input logic [CNT_W-1:0] resid,
   input logic             host_irq,
   input logic             dev_ack,
   input logic             mem_rd_stb,
   input logic             mem_wr_stb,
   input logic             host_wr,
   input logic [2:0]       host_sel
);
   logic cnt_write;
   assign cnt_write = host_wr && (host_sel == 3'd3 || host_sel == 3'd4 || host_sel == 3'd5);

   a_r8_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !host_irq);

   a_r9_irq_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
      ((resid != '0) || held) |-> !host_irq);

   a_r7_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((resid == '0) && !held) |=> (!mem_rd_stb && !mem_wr_stb && !dev_ack));

   a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> !dev_ack);

   a_r5_resid_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_stb && !cnt_write) |=> (resid == $past(resid) - CNT_W'(1)));

   a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_rel |=> (!sticky_conf && !sticky_berr && !held));

   a_r10_conf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_conf && fifo_rel) |=> sticky_conf);

   a_r11_halt_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_conf || sticky_berr) |=> (!mem_rd_stb || !$past(sticky_conf || sticky_berr, 2)));
endmodule

bind scsi_dma_ctl sdma_chk #(.CNT_W(CNT_W)) u_sdma_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .fifo_rel(fifo_rel), .held(held),
   .sticky_conf(sticky_conf), .sticky_berr(sticky_berr), .resid(resid),
   .host_irq(host_irq), .dev_ack(dev_ack), .mem_rd_stb(mem_rd_stb),
   .mem_wr_stb(mem_wr_stb), .host_wr(host_wr), .host_sel(host_sel)
);

// File: tb/test_scsi_dma_ctl.sv
`timescale 1ns/1ps
module test_scsi_dma_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [2:0]  host_sel = 3'd0;
   logic [15:0] host_wdata = 16'h0;
   logic [15:0] host_rdata;
   logic        scsi_irq = 1'b0;
   logic        host_irq;
   logic        dev_req = 1'b0;
   logic        dev_ack, mem_rd_stb, mem_wr_stb;
   logic [23:0] dma_addr;
   logic        err_conflict = 1'b0;
   logic        err_bus = 1'b0;
   logic        pack_flush;

   int errors = 0;
   int checks = 0;
   int n_ack = 0, n_rd = 0, n_wr = 0;

   always #2.5 clk = ~clk;

   scsi_dma_ctl i_scsi_dma_ctl (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .scsi_irq(scsi_irq),
      .host_irq(host_irq), .dev_req(dev_req), .dev_ack(dev_ack),
      .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb), .dma_addr(dma_addr),
      .err_conflict(err_conflict), .err_bus(err_bus), .pack_flush(pack_flush)
   );

   always @(negedge clk) begin
      n_ack <= n_ack + int'(dev_ack);
      n_rd  <= n_rd + int'(mem_rd_stb);
      n_wr  <= n_wr + int'(mem_wr_stb);
   end

   // {write select, write data, read select, expected read}
   localparam logic [37:0] VEC [0:7] = '{
      {3'd1, 16'h12AB, 3'd1, 16'h00AB},
      {3'd2, 16'h3457, 3'd2, 16'h3456},
      {3'd3, 16'h1234, 3'd3, 16'h0034},
      {3'd4, 16'h0010, 3'd5, 16'h0010},
      {3'd5, 16'h0007, 3'd4, 16'h0010},
      {3'd5, 16'h0009, 3'd5, 16'h0009},
      {3'd0, 16'h0706, 3'd0, 16'h0006},
      {3'd0, 16'h0000, 3'd0, 16'h0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [15:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_sel = s; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [15:0] d);
      host_sel = s;
      #0.5;
      d = host_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic req_pulse();
      @(negedge clk);
      dev_req = 1'b1;
      @(negedge clk);
      dev_req = 1'b0;
      idle(4);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int a0, r0, w0;
      idle(3);
      rst_n = 1'b1;
      scsi_irq = 1'b1;
      idle(2);

      // R1 reset state
      rd(3'd0, v); check("R1 ctrl", 32'(v), 32'h0004);
      for (int s = 1; s <= 5; s++) begin
         rd(3'(s), v); check("R1 reg", 32'(v), 32'h0);
      end
      check("R1 outputs", {28'h0, dev_ack, mem_rd_stb, mem_wr_stb, host_irq}, 32'h0);

      // register table walk (R2 R3 R4)
      for (int i = 0; i < 8; i++) begin
         logic [2:0] ws, rs;
         ws = VEC[i][37:35];
         rs = VEC[i][18:16];
         wr(ws, VEC[i][34:19]);
         rd(rs, v);
         if (ws == 3'd0)      check("R2 table", 32'(v), 32'(VEC[i][15:0]));
         else if (ws <= 3'd2) check("R3 table", 32'(v), 32'(VEC[i][15:0]));
         else                 check("R4 table", 32'(v), 32'(VEC[i][15:0]));
      end
      check("R10 flush pin", 32'(pack_flush), 32'h1);
      wr(3'd0, 16'h0004);
      check("R10 flush released", 32'(pack_flush), 32'h0);

      // R8 R9 interrupt gating
      wr(3'd3, 16'h0000); wr(3'd4, 16'h0000); wr(3'd5, 16'h0000);
      idle(1); check("R8 irq off when run clear", 32'(host_irq), 32'h0);
      wr(3'd0, 16'h0005);
      idle(1); check("R8 irq passes", 32'(host_irq), 32'h1);
      scsi_irq = 1'b0;
      idle(1); check("R8 irq follows source", 32'(host_irq), 32'h0);
      scsi_irq = 1'b1;
      wr(3'd5, 16'h0003);
      idle(2); check("R9 irq held by count", 32'(host_irq), 32'h0);
      wr(3'd0, 16'h0004);

      // R5 R3 receive transfer
      wr(3'd1, 16'h0000); wr(3'd2, 16'h0100);
      wr(3'd4, 16'h0003);
      a0 = n_ack; w0 = n_wr; r0 = n_rd;
      wr(3'd0, 16'h0005);
      dev_req = 1'b1;
      idle(12);
      check("R5 acks", 32'(n_ack - a0), 32'd3);
      check("R5 writes", 32'(n_wr - w0), 32'd3);
      check("R5 no fetch", 32'(n_rd - r0), 32'd0);
      rd(3'd5, v); check("R5 resid zero", 32'(v), 32'h0);
      rd(3'd2, v); check("R3 address advanced", 32'(v), 32'h0103);
      check("R3 dma_addr", 32'(dma_addr), 32'h000103);
      // R7 zero count idle with run set
      a0 = n_ack;
      idle(8);
      check("R7 no ack at zero", 32'(n_ack - a0), 32'd0);
      dev_req = 1'b0;
      wr(3'd0, 16'h0004);

      // R6 send, full transfer
      wr(3'd4, 16'h0002);
      a0 = n_ack; r0 = n_rd; w0 = n_wr;
      wr(3'd0, 16'h0007);
      idle(4);
      rd(3'd5, v); check("R6 prefetch resid", 32'(v), 32'h1);
      rd(3'd0, v); check("R2 held flag", 32'(v), 32'h0407);
      dev_req = 1'b1;
      idle(12);
      dev_req = 1'b0;
      check("R6 full acks", 32'(n_ack - a0), 32'd2);
      check("R6 full fetches", 32'(n_rd - r0), 32'd2);
      check("R6 no mem write", 32'(n_wr - w0), 32'd0);
      rd(3'd5, v); check("R6 full resid", 32'(v), 32'h0);
      wr(3'd0, 16'h0006);

      // R6 send, partial transfer
      wr(3'd4, 16'h0005);
      a0 = n_ack;
      wr(3'd0, 16'h0007);
      idle(4);
      req_pulse();
      req_pulse();
      check("R6 partial acks", 32'(n_ack - a0), 32'd2);
      rd(3'd5, v); check("R6 partial resid", 32'(v), 32'h2);
      wr(3'd0, 16'h0006);
      wr(3'd5, 16'h0000);
      wr(3'd0, 16'h0007);
      idle(1);
      check("R9 irq held by FIFO byte", 32'(host_irq), 32'h0);
      wr(3'd0, 16'h0003);
      check("R10 flush active", 32'(pack_flush), 32'h1);
      wr(3'd0, 16'h0005);
      rd(3'd0, v); check("R10 FIFO emptied", 32'(v), 32'h0005);
      check("R9 irq after flush", 32'(host_irq), 32'h1);
      wr(3'd0, 16'h0004);

      // R10 R11 sticky errors
      @(negedge clk); err_conflict = 1'b1;
      @(negedge clk); err_conflict = 1'b0;
      idle(2);
      rd(3'd0, v); check("R10 conflict sticky", 32'(v), 32'h0104);
      wr(3'd4, 16'h0002);
      a0 = n_ack;
      wr(3'd0, 16'h0005);
      @(negedge clk); err_bus = 1'b1;
      @(negedge clk); err_bus = 1'b0;
      dev_req = 1'b1;
      idle(10);
      check("R11 halted by error", 32'(n_ack - a0), 32'd0);
      rd(3'd0, v); check("R10 both flags", 32'(v), 32'h0305);
      dev_req = 1'b0;
      wr(3'd0, 16'h0001);
      wr(3'd0, 16'h0005);
      rd(3'd0, v); check("R10 flags cleared", 32'(v), 32'h0005);
      dev_req = 1'b1;
      idle(10);
      dev_req = 1'b0;
      check("R11 resumes after clear", 32'(n_ack - a0), 32'd2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule